// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the serial slave of a sensor-style device. A host reaches a map of 64 byte-wide registers over a four-wire serial link that runs in clock-idle-high mode. The slave samples the host data line on rising serial-clock edges and changes its own data line on falling edges. The serial clock, the select line and the host data line come in without any timing relation to the system clock. Each is passed through a two-flop synchroniser, and edges are found in the system clock domain. The serial clock must therefore run well below the system clock; four or more system cycles per serial half-period is enough.

A transaction opens when the active-low select line falls. The first byte is a command. Its top bit chooses read (1) or write (0). The next bit asks for a multi-byte burst. The low six bits give the starting register address. Every data byte after the command is either stored into the map or shifted out to the host. When the burst bit is set, the address moves up by one after each byte. When it is clear, every byte goes to the same register.

The map has four regions:
- Address 0x00 returns a fixed identification value.
- Addresses 0x01 to 0x2F hold general read/write bytes.
- Addresses 0x32 to 0x37 show three 16-bit sample inputs as low/high byte pairs. Reading a low byte freezes a coherent copy of all three samples.
- All other addresses read as zero and ignore writes.

Top module: `spi_regmap_slave`

## Requirements
- R1: A falling edge on the active-low select opens a transaction in the command phase. A rising edge returns the slave to idle and forces the host-facing data output low. A data byte cut short by the rising edge is discarded.
- R2: The command byte is taken most significant bit first. Bit 7 = 1 selects a read and 0 a write, bit 6 is the burst flag, and bits 5..0 are the register address.
- R3: Data bytes travel most significant bit first. Write data is sampled from the host line on rising serial-clock edges. Read data is placed on the output after falling edges, starting with the falling edge that follows the eighth command bit.
- R4: With the burst flag set, the register address increments by one after every complete data byte, wrapping from 0x3F to 0x00.
- R5: With the burst flag clear, every data byte of the transaction accesses the address named in the command.
- R6: Registers 0x01 through 0x2F reset to 0x00, store written bytes and return them on read.
- R7: Register 0x00 always reads the identification value (default 0xE5) and ignores writes.
- R8: Registers 0x30, 0x31, 0x38 and 0x39 read as 0x00. Writes to any address from 0x30 to 0x39 are ignored.
- R9: Sample inputs appear at 0x32/0x33 (first), 0x34/0x35 (second) and 0x36/0x37 (third), with bits 7..0 at the even address and bits 15..8 at the odd address.
- R10: Reading a low sample byte (0x32, 0x34 or 0x36) returns the live low byte and at the same moment captures all three samples. High-byte reads return the captured values.
- R11: Addresses 0x3A to 0x3F read as 0x00 and discard writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from the host, idle high |
| spiCsN | input | 1 | Active-low select from the host |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host, low when idle |
| sampleA | input | SAMPLE_W | First sample value |
| sampleB | input | SAMPLE_W | Second sample value |
| sampleC | input | SAMPLE_W | Third sample value |

## Verification
The bench targets these corner cases:
- A burst that starts at 0x3F. It writes a discarded byte, a refused identification byte and a real byte at 0x01. A slave that fails to wrap, or that guards addresses by range incorrectly, reads back a changed identification value or a wrong 0x01.
- A burst that walks across the 0x2F/0x30 border. It catches an off-by-one in the writable window.
- A high sample byte read after the sample inputs have changed. A slave without the capture returns the new high byte instead of the old one.
- A single-address write with three bytes. A slave that increments without the burst flag corrupts the next register.
- A write cut off after four data bits by the select rising. A slave that commits partial bytes reads back a changed register.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } ctrlState_e;

  // strobes from the framing control to the datapath, one cycle each
  typedef struct packed {
    logic clear;      // select edge: drop output, restart framing
    logic sampleBit;  // rising serial edge inside a transaction
    logic cmdDone;    // eighth command bit sampled
    logic dataDone;   // eighth data bit sampled
    logic driveBit;   // falling serial edge in the data phase
  } ctrlStrobe_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int               WIDTH     = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinAsync,
  output logic [WIDTH-1:0] pinLevel,
  output logic [WIDTH-1:0] pinRise,
  output logic [WIDTH-1:0] pinFall
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;
  logic [WIDTH-1:0] stagePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1    <= RESET_VAL;
      stage2    <= RESET_VAL;
      stagePrev <= RESET_VAL;
    end else begin
      stage1    <= pinAsync;
      stage2    <= stage1;
      stagePrev <= stage2;
    end
  end

  assign pinLevel = stage2;
  assign pinRise  = stage2 & ~stagePrev;
  assign pinFall  = ~stage2 & stagePrev;

endmodule

// File: rtl/spi_regmap_ctrl.sv
module spi_regmap_ctrl
  import spi_regmap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        csFall,
  input  logic        csRise,
  output ctrlStrobe_t strb,
  output ctrlState_e  state
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             csEdge;

  assign csEdge = csFall | csRise;

  always_comb begin
    strb           = '0;
    strb.clear     = csEdge;
    strb.sampleBit = sclkRise && !csEdge && (state != ST_IDLE);
    strb.cmdDone   = strb.sampleBit && (state == ST_CMD)  && (bitCnt == LAST_BIT);
    strb.dataDone  = strb.sampleBit && (state == ST_DATA) && (bitCnt == LAST_BIT);
    strb.driveBit  = sclkFall && !csEdge && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (csFall) begin
      state  <= ST_CMD;
      bitCnt <= '0;
    end else if (csRise) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (strb.sampleBit) begin
      bitCnt <= bitCnt + CNT_W'(1);
      if (strb.cmdDone) state <= ST_DATA;
    end
  end

endmodule

// File: rtl/spi_regmap_dp.sv
module spi_regmap_dp
  import spi_regmap_pkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                ADDR_W      = 6,
  parameter int                SAMPLE_W    = 16,
  parameter int                NUM_AXES    = 3,
  parameter int                WR_FIRST    = 1,
  parameter int                WR_LAST     = 47,
  parameter int                SAMPLE_BASE = 50,
  parameter logic [BYTE_W-1:0] ID_VALUE    = 8'hE5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strb,
  input  logic                         mosiBit,
  input  logic [NUM_AXES*SAMPLE_W-1:0] samplesFlat,
  output logic                         misoBit,
  output logic [ADDR_W-1:0]            curAddr,
  output logic                         multiByte
);

  localparam int SAMPLE_LAST = SAMPLE_BASE + 2 * NUM_AXES - 1;

  logic [BYTE_W-2:0]   rxShift;
  logic [BYTE_W-1:0]   rxByte;
  logic [BYTE_W-1:0]   txShift;
  logic                isRead;
  logic [BYTE_W-1:0]   regFile [WR_FIRST:WR_LAST];
  logic [SAMPLE_W-1:0] liveSample [NUM_AXES];
  logic [SAMPLE_W-1:0] snapSample [NUM_AXES];
  logic [ADDR_W-1:0]   cmdAddr;
  logic [ADDR_W-1:0]   nextAddr;
  logic [ADDR_W-1:0]   loadAddr;
  logic                loadRead;

  for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
    assign liveSample[k] = samplesFlat[k*SAMPLE_W +: SAMPLE_W];
  end

  assign rxByte   = {rxShift, mosiBit};
  assign cmdAddr  = rxByte[ADDR_W-1:0];
  assign nextAddr = multiByte ? curAddr + ADDR_W'(1) : curAddr;
  assign loadAddr = strb.cmdDone ? cmdAddr : nextAddr;
  assign loadRead = strb.cmdDone ? rxByte[BYTE_W-1] : isRead;

  function automatic logic isSampleLow(input int a);
    return (a >= SAMPLE_BASE) && (a <= SAMPLE_LAST) && (((a - SAMPLE_BASE) % 2) == 0);
  endfunction

  function automatic logic [BYTE_W-1:0] readByte(input int a);
    logic [BYTE_W-1:0] v;
    int k;
    v = '0;
    if (a == 0) begin
      v = ID_VALUE;
    end else if (a >= WR_FIRST && a <= WR_LAST) begin
      v = regFile[a];
    end else if (a >= SAMPLE_BASE && a <= SAMPLE_LAST) begin
      k = (a - SAMPLE_BASE) / 2;
      if (isSampleLow(a)) v = liveSample[k][BYTE_W-1:0];
      else                v = snapSample[k][2*BYTE_W-1:BYTE_W];
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      misoBit   <= 1'b0;
      isRead    <= 1'b0;
      multiByte <= 1'b0;
      curAddr   <= '0;
      for (int i = WR_FIRST; i <= WR_LAST; i++) regFile[i] <= '0;
      for (int k = 0; k < NUM_AXES; k++) snapSample[k] <= '0;
    end else begin
      if (strb.clear) begin
        misoBit <= 1'b0;
        rxShift <= '0;
      end
      if (strb.sampleBit) begin
        rxShift <= rxByte[BYTE_W-2:0];
      end
      if (strb.cmdDone) begin
        isRead    <= rxByte[BYTE_W-1];
        multiByte <= rxByte[BYTE_W-2];
        curAddr   <= cmdAddr;
      end
      if (strb.dataDone) begin
        if (!isRead && int'(curAddr) >= WR_FIRST && int'(curAddr) <= WR_LAST)
          regFile[int'(curAddr)] <= rxByte;
        curAddr <= nextAddr;
      end
      if (strb.cmdDone || strb.dataDone) begin
        txShift <= readByte(int'(loadAddr));
        if (loadRead && isSampleLow(int'(loadAddr))) begin
          for (int k = 0; k < NUM_AXES; k++) snapSample[k] <= liveSample[k];
        end
      end
      if (strb.driveBit) begin
        misoBit <= isRead ? txShift[BYTE_W-1] : 1'b0;
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave
  import spi_regmap_pkg::*;
#(
  parameter int         SAMPLE_W = 16,
  parameter logic [7:0] ID_VALUE = 8'hE5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spiSclk,
  input  logic                spiCsN,
  input  logic                spiMosi,
  output logic                spiMiso,
  input  logic [SAMPLE_W-1:0] sampleA,
  input  logic [SAMPLE_W-1:0] sampleB,
  input  logic [SAMPLE_W-1:0] sampleC
);

  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 6;
  localparam int NUM_AXES    = 3;
  localparam int WR_FIRST    = 1;
  localparam int WR_LAST     = 47;
  localparam int SAMPLE_BASE = 50;

  logic [2:0]        pinLevel;
  logic [2:0]        pinRise;
  logic [2:0]        pinFall;
  ctrlStrobe_t       strb;
  ctrlState_e        ctrlState;
  logic [ADDR_W-1:0] curAddr;
  logic              multiByte;

  // bit 2 = serial clock, bit 1 = select, bit 0 = host data
  spi_pin_sync #(
    .WIDTH    (3),
    .RESET_VAL(3'b110)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .pinAsync({spiSclk, spiCsN, spiMosi}),
    .pinLevel(pinLevel),
    .pinRise (pinRise),
    .pinFall (pinFall)
  );

  spi_regmap_ctrl #(
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclkRise(pinRise[2]),
    .sclkFall(pinFall[2]),
    .csFall  (pinFall[1]),
    .csRise  (pinRise[1]),
    .strb    (strb),
    .state   (ctrlState)
  );

  spi_regmap_dp #(
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W),
    .SAMPLE_W   (SAMPLE_W),
    .NUM_AXES   (NUM_AXES),
    .WR_FIRST   (WR_FIRST),
    .WR_LAST    (WR_LAST),
    .SAMPLE_BASE(SAMPLE_BASE),
    .ID_VALUE   (ID_VALUE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mosiBit    (pinLevel[0]),
    .samplesFlat({sampleC, sampleB, sampleA}),
    .misoBit    (spiMiso),
    .curAddr    (curAddr),
    .multiByte  (multiByte)
  );

endmodule

// File: rtl/spi_regmap_chk.sv
module spi_regmap_chk
  import spi_regmap_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        spiMiso,
  input ctrlStrobe_t strb,
  input ctrlState_e  ctrlState,
  input logic [5:0]  curAddr,
  input logic        multiByte
);

  // R1
  cs_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (spiMiso == 1'b0));

  // R2
  cmd_to_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdDone |=> (ctrlState == ST_DATA));

  // R3
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiMiso) |-> $past(strb.driveBit || strb.clear));

  // R4
  burst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataDone && multiByte) |=> (curAddr == $past(curAddr) + 6'd1));

  // R5
  single_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataDone && !multiByte) |=> $stable(curAddr));

endmodule

bind spi_regmap_slave spi_regmap_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .spiMiso  (spiMiso),
  .strb     (strb),
  .ctrlState(ctrlState),
  .curAddr  (curAddr),
  .multiByte(multiByte)
);

// File: tb/spi_regmap_slave_tb.sv
module spi_regmap_slave_tb;

  localparam int HP = 8;  // system cycles per serial half-period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiSclk = 1'b1;
  logic        spiCsN = 1'b1;
  logic        spiMosi = 1'b0;
  logic        spiMiso;
  logic [15:0] sampleA = '0;
  logic [15:0] sampleB = '0;
  logic [15:0] sampleC = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] actQ[$];
  logic [7:0] wrQ[$];

  always #5 clk = ~clk;

  spi_regmap_slave u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .spiSclk(spiSclk),
    .spiCsN (spiCsN),
    .spiMosi(spiMosi),
    .spiMiso(spiMiso),
    .sampleA(sampleA),
    .sampleB(sampleB),
    .sampleC(sampleC)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect8(input logic [7:0] v, input string tag);
    expItem_t e;
    e.val = v;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic spiBit(input logic b, output logic r);
    spiSclk = 1'b0;
    spiMosi = b;
    waitCyc(HP);
    r = spiMiso;
    spiSclk = 1'b1;
    waitCyc(HP);
  endtask

  // full transaction; write bytes come from wrQ, read bytes go to actQ
  task automatic spiTxn(input logic [7:0] cmd, input int nBytes);
    logic r;
    logic [7:0] rx;
    logic [7:0] tx;
    spiCsN = 1'b0;
    waitCyc(HP);
    for (int i = 7; i >= 0; i--) spiBit(cmd[i], r);
    for (int n = 0; n < nBytes; n++) begin
      tx = cmd[7] ? 8'h00 : wrQ.pop_front();
      rx = '0;
      for (int i = 7; i >= 0; i--) begin
        spiBit(tx[i], r);
        rx[i] = r;
      end
      if (cmd[7]) actQ.push_back(rx);
    end
    waitCyc(HP);
    spiCsN = 1'b1;
    waitCyc(2 * HP);
  endtask

  task automatic readOne(input logic [5:0] a, input logic [7:0] v, input string tag);
    expect8(v, tag);
    spiTxn({2'b10, a}, 1);
  endtask

  task automatic writeOne(input logic [5:0] a, input logic [7:0] v);
    wrQ.push_back(v);
    spiTxn({2'b00, a}, 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare each received byte against the scoreboard head
  always @(negedge clk) begin
    if (actQ.size() > 0) begin
      logic [7:0] a;
      expItem_t e;
      a = actQ.pop_front();
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected byte: actual %02h expected none", a);
      end else begin
        e = expQ.pop_front();
        if (a !== e.val) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", e.tag, a, e.val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic r;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);

    // R1: idle output after reset
    checks++;
    if (spiMiso !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset miso: actual %b expected 0", spiMiso);
    end

    // R7 / R2: identification read
    readOne(6'h00, 8'hE5, "R7 id read");

    // R6 / R3: single write and readback
    readOne(6'h05, 8'h00, "R6 reset value");
    writeOne(6'h05, 8'h3C);
    readOne(6'h05, 8'h3C, "R3 r6_ write readback");

    // R4: burst write and burst read
    wrQ = '{8'hA1, 8'hB2, 8'hC3};
    spiTxn(8'h50, 3);
    expect8(8'hA1, "R4 burst 0x10");
    expect8(8'hB2, "R4 burst 0x11");
    expect8(8'hC3, "R4 burst 0x12");
    spiTxn(8'hD0, 3);

    // R5: no increment without burst flag
    wrQ = '{8'h11, 8'h22, 8'h33};
    spiTxn(8'h20, 3);
    expect8(8'h33, "R5 last write wins");
    expect8(8'h00, "R5 neighbour untouched");
    spiTxn(8'hE0, 2);
    expect8(8'hA1, "R5 repeat read 1");
    expect8(8'hA1, "R5 repeat read 2");
    expect8(8'hA1, "R5 repeat read 3");
    spiTxn(8'h90, 3);

    // R7 / R8: read-only registers
    writeOne(6'h00, 8'hFF);
    writeOne(6'h30, 8'h77);
    writeOne(6'h38, 8'h66);
    readOne(6'h00, 8'hE5, "R7 id after write");
    readOne(6'h30, 8'h00, "R8 0x30 after write");
    readOne(6'h38, 8'h00, "R8 0x38 after write");

    // R6 / R8: burst across the writable border
    wrQ = '{8'h01, 8'h02, 8'h03, 8'h04};
    spiTxn(8'h6E, 4);
    expect8(8'h01, "R6 0x2E");
    expect8(8'h02, "R6 0x2F");
    expect8(8'h00, "R8 0x30");
    expect8(8'h00, "R8 0x31");
    spiTxn(8'hEE, 4);

    // R11: out-of-range addresses
    writeOne(6'h3A, 8'h55);
    for (int i = 0; i < 6; i++) expect8(8'h00, "R11 high range read");
    spiTxn(8'hFA, 6);

    // R4 / R11 / R7: wrap from 0x3F to 0x00
    wrQ = '{8'h99, 8'h42, 8'h6B};
    spiTxn(8'h7F, 3);
    expect8(8'h00, "R11 0x3E");
    expect8(8'h00, "R11 0x3F discarded");
    expect8(8'hE5, "R4 wrap to id");
    expect8(8'h6B, "R4 wrap write 0x01");
    spiTxn(8'hFE, 4);

    // R9: sample placement
    sampleA = 16'h1234;
    sampleB = 16'hABCD;
    sampleC = 16'h8001;
    waitCyc(4);
    expect8(8'h34, "R9 A low");
    expect8(8'h12, "R9 A high");
    expect8(8'hCD, "R9 B low");
    expect8(8'hAB, "R9 B high");
    expect8(8'h01, "R9 C low");
    expect8(8'h80, "R9 C high");
    spiTxn(8'hF2, 6);

    // R10: capture on low byte read
    readOne(6'h32, 8'h34, "R10 low capture");
    sampleA = 16'h5678;
    sampleB = 16'h0F0E;
    waitCyc(4);
    readOne(6'h33, 8'h12, "R10 held A high");
    readOne(6'h35, 8'hAB, "R10 held B high");
    readOne(6'h34, 8'h0E, "R10 live B low");
    readOne(6'h33, 8'h56, "R10 refreshed A high");

    // R1: write aborted after four data bits
    spiCsN = 1'b0;
    waitCyc(HP);
    for (int i = 7; i >= 0; i--) spiBit(((8'h05 >> i) & 8'h01) != 0, r);
    for (int i = 0; i < 4; i++) spiBit(1'b1, r);
    spiCsN = 1'b1;
    waitCyc(2 * HP);
    checks++;
    if (spiMiso !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle after abort: actual %b expected 0", spiMiso);
    end
    readOne(6'h05, 8'h3C, "R1 partial byte discarded");

    // R1: abort mid-command, then a clean transaction
    spiCsN = 1'b0;
    waitCyc(HP);
    for (int i = 0; i < 3; i++) spiBit(1'b1, r);
    spiCsN = 1'b1;
    waitCyc(2 * HP);
    readOne(6'h2F, 8'h02, "R1 restart after command abort");

    waitCyc(10);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3 missing bytes: actual %0d left expected 0", expQ.size());
    end
    finish();
  end

endmodule